// File: doc/BRIEF.md
# Four-port GPIO register bank

This block is a byte-wide register bank that controls four 8-bit general-purpose I/O ports. Each port has an output value register, an output mode register, a direction register and a read-only pin register. The bank also holds two shared select registers. A single-cycle bus slave accesses the bank with an address, a write strobe, a read strobe, write data and an access size. Read data and an error flag are combinational, so they are valid in the same cycle as the access. Writes take effect at the next rising clock edge.

The register map is sparse and fixed, and the reset values differ from register to register. The bank never masks an illegal write silently. If a write sets an unimplemented bit, uses a size other than one byte, hits an unmapped offset or targets a read-only register, the bank raises the error flag and keeps its state. The output registers drive the pads. The direction registers drive the per-bit output enables. The external pins are brought in through a two-flop synchronizer.

Top module: `gpio4_regbank`

## Requirements
- R1: Register offsets are fixed. Outputs are at 0x00, 0x01, 0x04 and 0x05, modes at 0x20, 0x21, 0x24 and 0x25, directions at 0x60, 0x61, 0x64 and 0x65, and pins at 0x80, 0x81, 0x84 and 0x85, for ports 0 to 3. The select registers are at 0x44 (first) and 0x48 (second). A legal read returns the stored value.
- R2: After reset every register reads 0x00, with two exceptions: the port 2 mode register reads 0xFF and the second select register reads 0x0F.
- R3: `bus_size` gives the byte count minus one, so only 2'b00 is legal. Any other size on a read or a write raises `bus_err`, returns 0x00 read data and changes no state.
- R4: An access to an offset outside the map raises `bus_err` and returns 0x00.
- R5: Some registers implement only part of the byte. Port 3 output, mode and direction registers hold bits 1:0. Port 0 and port 1 mode registers hold bit 0. The first select register holds bits 1:0 and the second holds bits 3:0. A write that sets any other bit raises `bus_err`, and the register keeps its old value.
- R6: A write to any pin register raises `bus_err` and changes nothing.
- R7: A read of offset 0x85 (port 3 pins) raises `bus_err` and returns 0x00.
- R8: A pin register shows `pad_in` through two flops. A value applied before a clock edge becomes readable after the second rising edge.
- R9: Port p occupies bits 8p+7..8p. `pad_out` carries the output register and `pad_oe` carries the direction register, where 1 enables the driver.
- R10: `bus_err` is asserted only during an illegal access. `bus_rdata` is 0x00 whenever there is no legal read.
- R11: Raising both the read strobe and the write strobe in one cycle raises `bus_err` and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset from the bank base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_size | input | 2 | Access size in bytes minus one |
| bus_rdata | output | 8 | Read data, same cycle |
| bus_err | output | 1 | Error response, same cycle |
| pad_out | output | 32 | Output values, port p at bits 8p+7..8p |
| pad_oe | output | 32 | Output enables, from the direction registers |
| pad_in | input | 32 | External pin levels |

## Verification
Corrupted register state shows up at `pad_out` and `pad_oe` in the cycle after the bad write. It also shows on `bus_rdata` when the register is next read back. Faulty legality logic shows up at once: `bus_err` is wrong in the cycle of the access, and a rejected write that still lands shows up as a changed pad or read-back value one cycle later. An off-by-one synchronizer depth makes a pin value appear one edge early or late, so the bench reads the pins after each of the two edges.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam int unsigned NPORT = 4;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 8;
  localparam int unsigned PW    = $clog2(NPORT);
  localparam int unsigned PADW  = NPORT * DW;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_OUT,
    RK_MODE,
    RK_SEL,
    RK_DIR,
    RK_PIN
  } rkind_e;

  // Implemented (writable) bits of a register
  function automatic logic [DW-1:0] wmask(rkind_e k, logic [PW-1:0] i);
    logic [DW-1:0] m;
    m = '0;
    unique case (k)
      RK_OUT, RK_DIR: m = (i == PW'(3)) ? 8'h03 : 8'hFF;
      RK_MODE: begin
        if (i == PW'(3))      m = 8'h03;
        else if (i == PW'(2)) m = 8'hFF;
        else                  m = 8'h01;
      end
      RK_SEL:  m = (i == PW'(0)) ? 8'h03 : 8'h0F;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Reset value of a register
  function automatic logic [DW-1:0] rstval(rkind_e k, logic [PW-1:0] i);
    logic [DW-1:0] v;
    v = '0;
    if (k == RK_MODE && i == PW'(2)) v = 8'hFF;
    if (k == RK_SEL  && i == PW'(1)) v = 8'h0F;
    return v;
  endfunction

  // A write is illegal if it hits a read-only register or an unimplemented bit
  function automatic logic wr_reject(rkind_e k, logic [PW-1:0] i, logic [DW-1:0] d);
    return (k == RK_PIN) || ((d & ~wmask(k, i)) != '0);
  endfunction
endpackage

// File: rtl/gpio4_addr_dec.sv
module gpio4_addr_dec
  import gpio4_pkg::*;
(
  input  logic [AW-1:0] addr,
  output rkind_e        kind,
  output logic [PW-1:0] idx
);
  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (addr[4:3] == 2'b00 && addr[1] == 1'b0) begin
      idx = {addr[2], addr[0]};
      unique case (addr[7:5])
        3'd0:    kind = RK_OUT;
        3'd1:    kind = RK_MODE;
        3'd3:    kind = RK_DIR;
        3'd4:    kind = RK_PIN;
        default: kind = RK_NONE;
      endcase
    end
    if (addr == 8'h44) begin
      kind = RK_SEL;
      idx  = PW'(0);
    end
    if (addr == 8'h48) begin
      kind = RK_SEL;
      idx  = PW'(1);
    end
  end
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
#(
  parameter int unsigned PIDX   = 0,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_out,
  input  logic          we_mode,
  input  logic          we_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_raw,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] pin_q
);
  localparam logic [PW-1:0] IDX = PW'(PIDX);

  logic [DW-1:0] sync_q [SYNC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= rstval(RK_OUT,  IDX);
      mode_q <= rstval(RK_MODE, IDX);
      dir_q  <= rstval(RK_DIR,  IDX);
    end else begin
      if (we_out)  out_q  <= wdata & wmask(RK_OUT,  IDX);
      if (we_mode) mode_q <= wdata & wmask(RK_MODE, IDX);
      if (we_dir)  dir_q  <= wdata & wmask(RK_DIR,  IDX);
    end
  end

  for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pin_raw;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign pin_q = sync_q[SYNC_N-1];
endmodule

// File: rtl/gpio4_sel_regs.sv
module gpio4_sel_regs
  import gpio4_pkg::*;
#(
  parameter int unsigned NSEL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSEL-1:0] we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sel_q [NSEL]
);
  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel_q[k] <= rstval(RK_SEL, PW'(k));
      else if (we[k]) sel_q[k] <= wdata & wmask(RK_SEL, PW'(k));
    end
  end
endmodule

// File: rtl/gpio4_regbank.sv
module gpio4_regbank
  import gpio4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [1:0]      bus_size,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic [PADW-1:0] pad_out,
  output logic [PADW-1:0] pad_oe,
  input  logic [PADW-1:0] pad_in
);
  localparam int unsigned NSEL = 2;

  rkind_e        kind;
  logic [PW-1:0] idx;

  // Named internal events
  logic access, size_bad, map_bad, dual_bad, wr_bad, rd_bad;
  logic wr_commit, rd_ok;

  logic [DW-1:0] out_q  [NPORT];
  logic [DW-1:0] mode_q [NPORT];
  logic [DW-1:0] dir_q  [NPORT];
  logic [DW-1:0] pin_q  [NPORT];
  logic [DW-1:0] sel_q  [NSEL];
  logic [NSEL-1:0] sel_we;

  gpio4_addr_dec i_dec (
    .addr (bus_addr),
    .kind (kind),
    .idx  (idx)
  );

  assign access    = bus_wr | bus_rd;
  assign size_bad  = bus_size != 2'b00;
  assign map_bad   = kind == RK_NONE;
  assign dual_bad  = bus_wr & bus_rd;
  assign wr_bad    = bus_wr & wr_reject(kind, idx, bus_wdata);
  assign rd_bad    = bus_rd & (kind == RK_PIN) & (idx == PW'(3));
  assign bus_err   = access & (size_bad | map_bad | dual_bad | wr_bad | rd_bad);
  assign wr_commit = bus_wr & ~bus_err;
  assign rd_ok     = bus_rd & ~bus_err;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit = wr_commit & (idx == PW'(p));
    gpio4_port #(.PIDX(p)) i_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_out  (hit & (kind == RK_OUT)),
      .we_mode (hit & (kind == RK_MODE)),
      .we_dir  (hit & (kind == RK_DIR)),
      .wdata   (bus_wdata),
      .pin_raw (pad_in[p*DW +: DW]),
      .out_q   (out_q[p]),
      .mode_q  (mode_q[p]),
      .dir_q   (dir_q[p]),
      .pin_q   (pin_q[p])
    );
    assign pad_out[p*DW +: DW] = out_q[p];
    assign pad_oe[p*DW +: DW]  = dir_q[p];
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_selwe
    assign sel_we[k] = wr_commit & (kind == RK_SEL) & (idx == PW'(k));
  end

  gpio4_sel_regs #(.NSEL(NSEL)) i_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sel_we),
    .wdata (bus_wdata),
    .sel_q (sel_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      unique case (kind)
        RK_OUT:  bus_rdata = out_q[idx];
        RK_MODE: bus_rdata = mode_q[idx];
        RK_DIR:  bus_rdata = dir_q[idx];
        RK_PIN:  bus_rdata = pin_q[idx];
        RK_SEL:  bus_rdata = sel_q[idx[0]];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio4_regbank_chk.sv
module gpio4_regbank_chk
  import gpio4_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [1:0]      bus_size,
  input logic [DW-1:0]   bus_rdata,
  input logic            bus_err,
  input logic [PADW-1:0] pad_out,
  input logic [PADW-1:0] pad_oe,
  input logic            wr_commit
);
  p_size_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr | bus_rd) && bus_size != 2'b00) |-> bus_err);

  p_rejected_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_err) |=> ($stable(pad_out) && $stable(pad_oe)));

  p_port3_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out[PADW-1 -: 6] == '0) && (pad_oe[PADW-1 -: 6] == '0));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr | bus_rd) |-> (!bus_err && bus_rdata == '0));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == '0);

  p_commit_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (!bus_err && !bus_rd));
endmodule

bind gpio4_regbank gpio4_regbank_chk i_chk (.*);

// File: tb/test_gpio4_regbank.sv
`timescale 1ns/1ps
module test_gpio4_regbank;
  localparam int NV = 30;
  localparam int TIMEOUT_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [1:0]  bus_size = '0;
  logic [7:0]  bus_rdata;
  logic        bus_err;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic [31:0] pad_in = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio4_regbank i_gpio4_regbank (.*);

  // {wr, rd, addr, wdata, size, exp_rdata, exp_err}
  localparam logic [28:0] VEC [NV] = '{
    {1'b1,1'b0,8'h00,8'hA5,2'd0,8'h00,1'b0}, // R1 write port0 out
    {1'b0,1'b1,8'h00,8'h00,2'd0,8'hA5,1'b0}, // R1
    {1'b1,1'b0,8'h05,8'h03,2'd0,8'h00,1'b0}, // R5 port3 out legal
    {1'b0,1'b1,8'h05,8'h00,2'd0,8'h03,1'b0},
    {1'b1,1'b0,8'h05,8'h04,2'd0,8'h00,1'b1}, // R5 port3 bit2
    {1'b0,1'b1,8'h05,8'h00,2'd0,8'h03,1'b0}, // R5 unchanged
    {1'b1,1'b0,8'h21,8'h01,2'd0,8'h00,1'b0}, // R5 port1 mode bit0
    {1'b0,1'b1,8'h21,8'h00,2'd0,8'h01,1'b0},
    {1'b1,1'b0,8'h20,8'h02,2'd0,8'h00,1'b1}, // R5 port0 mode bit1
    {1'b0,1'b1,8'h20,8'h00,2'd0,8'h00,1'b0},
    {1'b1,1'b0,8'h24,8'h3C,2'd0,8'h00,1'b0}, // R1 port2 mode full byte
    {1'b0,1'b1,8'h24,8'h00,2'd0,8'h3C,1'b0},
    {1'b1,1'b0,8'h44,8'h03,2'd0,8'h00,1'b0}, // R1 first select
    {1'b0,1'b1,8'h44,8'h00,2'd0,8'h03,1'b0},
    {1'b1,1'b0,8'h44,8'h04,2'd0,8'h00,1'b1}, // R5 first select bit2
    {1'b0,1'b1,8'h44,8'h00,2'd0,8'h03,1'b0},
    {1'b1,1'b0,8'h48,8'h0A,2'd0,8'h00,1'b0}, // R1 second select
    {1'b1,1'b0,8'h48,8'h10,2'd0,8'h00,1'b1}, // R5 second select bit4
    {1'b0,1'b1,8'h48,8'h00,2'd0,8'h0A,1'b0},
    {1'b1,1'b0,8'h64,8'hF0,2'd0,8'h00,1'b0}, // R1 port2 dir
    {1'b0,1'b1,8'h64,8'h00,2'd0,8'hF0,1'b0},
    {1'b1,1'b0,8'h02,8'h11,2'd0,8'h00,1'b1}, // R4 unmapped write
    {1'b0,1'b1,8'h02,8'h00,2'd0,8'h00,1'b1}, // R4 unmapped read
    {1'b0,1'b1,8'h85,8'h00,2'd0,8'h00,1'b1}, // R7
    {1'b1,1'b0,8'h80,8'hFF,2'd0,8'h00,1'b1}, // R6
    {1'b0,1'b1,8'h80,8'h00,2'd0,8'h00,1'b0}, // R6 pin unchanged
    {1'b1,1'b0,8'h01,8'h77,2'd1,8'h00,1'b1}, // R3 two-byte write
    {1'b0,1'b1,8'h01,8'h00,2'd0,8'h00,1'b0}, // R3 unchanged
    {1'b0,1'b1,8'h00,8'h00,2'd2,8'h00,1'b1}, // R3 wide read
    {1'b1,1'b0,8'h65,8'h02,2'd0,8'h00,1'b0}  // R1 port3 dir
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic r, input logic [7:0] a,
                     input logic [7:0] d, input logic [1:0] s,
                     output logic [7:0] rdv, output logic e);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; bus_size = s;
    #1;
    rdv = bus_rdata;
    e   = bus_err;
    @(posedge clk);
    #0.5;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    logic e;
    acc(1'b0, 1'b1, a, 8'h00, 2'd0, v, e);
    check(req, {v, 7'd0, e}, {exp, 8'd0});
  endtask

  initial begin : watchdog
    repeat (TIMEOUT_CYC) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset values
    check("R2 pads", {pad_out, pad_oe}, 64'h0);
    rd_chk("R2 port2 mode", 8'h24, 8'hFF);
    rd_chk("R2 second select", 8'h48, 8'h0F);
    rd_chk("R2 first select", 8'h44, 8'h00);
    rd_chk("R2 port0 out", 8'h00, 8'h00);
    rd_chk("R2 port3 dir", 8'h65, 8'h00);
    rd_chk("R2 port1 pin", 8'h81, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] t;
      t = VEC[i];
      acc(t[28], t[27], t[26:19], t[18:11], t[10:9], v, e);
      check($sformatf("R1/R3-R7 vector %0d", i), {v, 7'd0, e}, {t[8:1], 7'd0, t[0]});
    end

    // R9 pad mapping
    check("R9 pad_out", pad_out, 32'h0300_00A5);
    check("R9 pad_oe",  pad_oe,  32'h02F0_0000);

    // R10 idle cycle
    acc(1'b0, 1'b0, 8'h00, 8'h00, 2'd0, v, e);
    check("R10 idle", {v, 7'd0, e}, 16'h0000);

    // R11 simultaneous strobes
    acc(1'b1, 1'b1, 8'h00, 8'h00, 2'd0, v, e);
    check("R11 dual strobe", {v, 7'd0, e}, 16'h0001);
    rd_chk("R11 unchanged", 8'h00, 8'hA5);

    // R8 two-flop pin path
    @(negedge clk);
    pad_in[15:8] = 8'h5A;
    rd_chk("R8 after one edge", 8'h81, 8'h00);
    rd_chk("R8 after two edges", 8'h81, 8'h5A);
    pad_in[23:16] = 8'hC3;
    repeat (2) @(posedge clk);
    rd_chk("R8 port2 pin", 8'h84, 8'hC3);
    acc(1'b0, 1'b1, 8'h85, 8'h00, 2'd0, v, e);
    check("R7 port3 pin read", {v, 7'd0, e}, 16'h0001);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule